// File: doc/BRIEF.md
# Seven-Register ALU Datapath Driven by a Control Word

This block is the execution core of a small processor: a bank of seven 8-bit general-purpose registers around one shared ALU. Every clock cycle a 14-bit control word arrives. Its fields pick two source operands, an ALU operation and a destination. The operands come from the register bank or from an external data bus. The ALU result leaves the block on an output bus every cycle. At the next rising edge the result is written into the chosen register, unless the destination code says that no register is written.

A transfer such as "R1 gets R2 plus R3" takes exactly one control word and one clock edge. The control word is the only control input. There is no handshake. An upstream sequencer presents a new word every cycle and a downstream consumer samples the result bus when it needs to. Reads from the bank are combinational, so the result bus always reflects the current control word, the external bus and the register contents.

Top module: `gpr_alu_datapath`

## Requirements
- R1: The control word is 14 bits. Bits [13:11] select operand A, bits [10:8] select operand B, bits [7:5] select the destination and bits [4:0] select the ALU operation.
- R2: An operand select code of 1 to 7 places register R1 to R7 on that operand. Code 0 places the external data bus on that operand. This holds for A and B independently.
- R3: A destination code of 0 writes no register. A code n of 1 to 7 writes the ALU result into register Rn alone, at the rising clock edge. All other registers keep their values.
- R4: Operation codes: 00000 passes A, 00001 gives A+1, 00010 gives A+B, 00101 gives A-B, 00110 gives A-1, 01000 gives A AND B, 01010 gives A OR B, 01100 gives A XOR B, 10000 shifts A right by one with a zero fill, and 11000 shifts A left by one with a zero fill. Every other code passes A unchanged. Arithmetic wraps modulo 256.
- R5: The carry output is the carry out of bit 7 for A+B and A+1. It is the borrow (1 when A < B unsigned) for A-B. It is 1 when A is 00h for A-1. It is the bit shifted out (A[0] or A[7]) for the two shifts. It is 0 for every other code.
- R6: The zero output is 1 exactly when the ALU result is 00h.
- R7: The result, carry and zero outputs are combinational functions of the present control word, external bus and register contents. They are valid in every cycle, whatever the destination code.
- R8: When one register is both a source and the destination, the operation uses its old value. The new value is visible from the next cycle on.
- R9: A synchronous active-high reset clears all seven registers to 00h at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; register writes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the register bank |
| ctrl_word | input | 14 | Control word: A select, B select, destination, operation |
| ext_data | input | 8 | External data bus, usable as either operand |
| alu_result | output | 8 | ALU result of the current control word |
| carry_out | output | 1 | Carry or borrow of the current operation |
| zero_flag | output | 1 | High when alu_result is zero |

## Verification
The registers cannot be read directly. Every stored value has to be loaded through the external bus with a pass operation and read back by pointing operand A at it with the destination turned off. The hardest case to reach is an operation whose source and destination are the same register, with the old value visible in the same cycle. The bench first loads a known value, then issues the self-targeting word and checks the result bus before the edge. It then reads the register back in the following cycle. Carry corners such as FFh+1, 00h-1 and 01h-02h need exact register contents, so each table vector preloads R1 and R2 before it runs its operation into R3.

// File: rtl/gpr_dp_pkg.sv
package gpr_dp_pkg;
  localparam int DEF_DATA_W = 8;
  localparam int DEF_SEL_W  = 3;
  localparam int OP_W       = 5;

  localparam logic [OP_W-1:0] OP_PASS = 5'b00000;
  localparam logic [OP_W-1:0] OP_INC  = 5'b00001;
  localparam logic [OP_W-1:0] OP_ADD  = 5'b00010;
  localparam logic [OP_W-1:0] OP_SUB  = 5'b00101;
  localparam logic [OP_W-1:0] OP_DEC  = 5'b00110;
  localparam logic [OP_W-1:0] OP_AND  = 5'b01000;
  localparam logic [OP_W-1:0] OP_OR   = 5'b01010;
  localparam logic [OP_W-1:0] OP_XOR  = 5'b01100;
  localparam logic [OP_W-1:0] OP_SHR  = 5'b10000;
  localparam logic [OP_W-1:0] OP_SHL  = 5'b11000;
endpackage

// File: rtl/cw_field_decode.sv
module cw_field_decode
  import gpr_dp_pkg::*;
#(
  parameter int SEL_W = DEF_SEL_W,
  localparam int NUM_REGS = (1 << SEL_W) - 1,
  localparam int CW_W = 3 * SEL_W + OP_W
) (
  input  logic [CW_W-1:0]     ctrl_word,
  output logic [SEL_W-1:0]    sel_a,
  output logic [SEL_W-1:0]    sel_b,
  output logic [SEL_W-1:0]    sel_dst,
  output logic [OP_W-1:0]     op_code,
  output logic [NUM_REGS-1:0] load_en
);
  // Field layout, most significant first: A select, B select, destination, op (R1)
  assign sel_a   = ctrl_word[CW_W-1 -: SEL_W];
  assign sel_b   = ctrl_word[CW_W-1-SEL_W -: SEL_W];
  assign sel_dst = ctrl_word[OP_W+SEL_W-1 -: SEL_W];
  assign op_code = ctrl_word[OP_W-1:0];

  // Destination decoder: code 0 enables nothing, code n enables slot n-1 (R3)
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    assign load_en[i] = (sel_dst == SEL_W'(i + 1));
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  localparam int NUM_REGS = (1 << SEL_W) - 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic [NUM_REGS-1:0]              load_en,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  reg_q
);
  logic [DATA_W-1:0] slot [NUM_REGS];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst)             slot[i] <= '0;
      else if (load_en[i]) slot[i] <= wr_data;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
    assign reg_q[i] = slot[i];

    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !load_en[i] |=> $stable(reg_q[i]))
      else $error("register slot %0d changed without a load", i);

    assert_capture_R8: assert property (@(posedge clk) disable iff (rst)
      load_en[i] |=> reg_q[i] == $past(wr_data))
      else $error("register slot %0d did not capture the result", i);

    assert_clear_R9: assert property (@(posedge clk)
      rst |=> reg_q[i] == '0)
      else $error("register slot %0d not cleared by reset", i);
  end

  assert_single_load_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_en))
    else $error("more than one register load enabled");
endmodule

// File: rtl/operand_pick.sv
module operand_pick #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3,
  localparam int NUM_REGS = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0]                sel,
  input  logic [DATA_W-1:0]               ext_data,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q,
  output logic [DATA_W-1:0]               operand
);
  logic [SEL_W-1:0] slot_idx;

  // Code 0 takes the external bus; code n reads register n (R2)
  always_comb begin
    slot_idx = sel - SEL_W'(1);
    if (sel == '0) operand = ext_data;
    else           operand = reg_q[slot_idx];
  end
endmodule

// File: rtl/alu_core.sv
module alu_core
  import gpr_dp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result,
  output logic              carry,
  output logic              zero
);
  localparam logic [DATA_W:0] ONE = (DATA_W+1)'(1);

  logic [DATA_W:0] wide_a;
  logic [DATA_W:0] wide_b;
  logic [DATA_W:0] wide_r;

  assign wide_a = {1'b0, opnd_a};
  assign wide_b = {1'b0, opnd_b};

  // Top bit of wide_r carries carry, borrow or shifted-out bit (R4, R5)
  always_comb begin
    case (op_code)
      OP_INC:  wide_r = wide_a + ONE;
      OP_ADD:  wide_r = wide_a + wide_b;
      OP_SUB:  wide_r = wide_a - wide_b;
      OP_DEC:  wide_r = wide_a - ONE;
      OP_AND:  wide_r = {1'b0, opnd_a & opnd_b};
      OP_OR:   wide_r = {1'b0, opnd_a | opnd_b};
      OP_XOR:  wide_r = {1'b0, opnd_a ^ opnd_b};
      OP_SHR:  wide_r = {opnd_a[0], 1'b0, opnd_a[DATA_W-1:1]};
      OP_SHL:  wide_r = {opnd_a[DATA_W-1], opnd_a[DATA_W-2:0], 1'b0};
      default: wide_r = wide_a;
    endcase
  end

  assign result = wide_r[DATA_W-1:0];
  assign carry  = wide_r[DATA_W];
  assign zero   = (result == '0);
endmodule

// File: rtl/gpr_alu_datapath.sv
module gpr_alu_datapath
  import gpr_dp_pkg::*;
#(
  parameter int DATA_W = DEF_DATA_W,
  parameter int SEL_W  = DEF_SEL_W,
  localparam int NUM_REGS = (1 << SEL_W) - 1,
  localparam int CW_W = 3 * SEL_W + OP_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CW_W-1:0]   ctrl_word,
  input  logic [DATA_W-1:0] ext_data,
  output logic [DATA_W-1:0] alu_result,
  output logic              carry_out,
  output logic              zero_flag
);
  logic [SEL_W-1:0]                sel_a;
  logic [SEL_W-1:0]                sel_b;
  logic [SEL_W-1:0]                sel_dst;
  logic [OP_W-1:0]                 op_code;
  logic [NUM_REGS-1:0]             load_en;
  logic [NUM_REGS-1:0][DATA_W-1:0] reg_q;
  logic [DATA_W-1:0]               opnd_a;
  logic [DATA_W-1:0]               opnd_b;

  cw_field_decode #(.SEL_W(SEL_W)) u_decode (
    .ctrl_word (ctrl_word),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .sel_dst   (sel_dst),
    .op_code   (op_code),
    .load_en   (load_en)
  );

  gpr_bank #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .load_en (load_en),
    .wr_data (alu_result),
    .reg_q   (reg_q)
  );

  operand_pick #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_pick_a (
    .sel      (sel_a),
    .ext_data (ext_data),
    .reg_q    (reg_q),
    .operand  (opnd_a)
  );

  operand_pick #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_pick_b (
    .sel      (sel_b),
    .ext_data (ext_data),
    .reg_q    (reg_q),
    .operand  (opnd_b)
  );

  alu_core #(.DATA_W(DATA_W)) u_alu (
    .op_code (op_code),
    .opnd_a  (opnd_a),
    .opnd_b  (opnd_b),
    .result  (alu_result),
    .carry   (carry_out),
    .zero    (zero_flag)
  );

  assert_nowrite_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_dst == '0) |-> (load_en == '0))
    else $error("destination 0 enabled a register load");

  assert_add_R4: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_ADD) |-> (DATA_W'(alu_result - opnd_b) == opnd_a))
    else $error("addition result inconsistent with operands");

  assert_sub_R4: assert property (@(posedge clk) disable iff (rst)
    (op_code == OP_SUB) |-> (DATA_W'(alu_result + opnd_b) == opnd_a))
    else $error("subtraction result inconsistent with operands");

  assert_zero_R6: assert property (@(posedge clk) disable iff (rst)
    zero_flag |-> (alu_result == '0))
    else $error("zero flag set with nonzero result");
endmodule

// File: tb/gpr_alu_datapath_bench.sv
module gpr_alu_datapath_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] PASS = 5'b00000, INC = 5'b00001, ADD = 5'b00010,
                         SUB = 5'b00101, DEC = 5'b00110, AND_ = 5'b01000,
                         OR_ = 5'b01010, XOR_ = 5'b01100, SHR = 5'b10000,
                         SHL = 5'b11000;
  localparam int NVEC = 18;
  // {op[29:25], a[24:17], b[16:9], result[8:1], carry[0]}
  localparam logic [29:0] VEC [NVEC] = '{
    {ADD,  8'h05, 8'h03, 8'h08, 1'b0},
    {ADD,  8'hFF, 8'h01, 8'h00, 1'b1},
    {SUB,  8'h10, 8'h01, 8'h0F, 1'b0},
    {SUB,  8'h01, 8'h02, 8'hFF, 1'b1},
    {SUB,  8'h33, 8'h33, 8'h00, 1'b0},
    {INC,  8'h7F, 8'h00, 8'h80, 1'b0},
    {INC,  8'hFF, 8'h12, 8'h00, 1'b1},
    {DEC,  8'h00, 8'h00, 8'hFF, 1'b1},
    {DEC,  8'h01, 8'h00, 8'h00, 1'b0},
    {AND_, 8'hF0, 8'h3C, 8'h30, 1'b0},
    {OR_,  8'hF0, 8'h0C, 8'hFC, 1'b0},
    {XOR_, 8'hAA, 8'hFF, 8'h55, 1'b0},
    {SHR,  8'h81, 8'h00, 8'h40, 1'b1},
    {SHL,  8'h81, 8'h00, 8'h02, 1'b1},
    {PASS, 8'h5A, 8'hC3, 8'h5A, 1'b0},
    {5'b11111, 8'hA5, 8'h11, 8'hA5, 1'b0},
    {5'b00011, 8'h00, 8'h44, 8'h00, 1'b0},
    {AND_, 8'h0F, 8'hF0, 8'h00, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ctrl_word = '0;
  logic [7:0]  ext_data = '0;
  logic [7:0]  alu_result;
  logic        carry_out;
  logic        zero_flag;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  gpr_alu_datapath u_gpr_alu_datapath (
    .clk        (clk),
    .rst        (rst),
    .ctrl_word  (ctrl_word),
    .ext_data   (ext_data),
    .alu_result (alu_result),
    .carry_out  (carry_out),
    .zero_flag  (zero_flag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [13:0] cw(input int a, input int b, input int d, input logic [4:0] op);
    return {3'(a), 3'(b), 3'(d), op};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // Present a word just after the falling edge; outputs settle before the rising edge
  task automatic drive(input logic [13:0] w, input logic [7:0] d);
    @(negedge clk);
    ctrl_word = w;
    ext_data  = d;
    #1;
  endtask

  task automatic read_reg(input int r, input logic [7:0] exp, input string tag);
    drive(cw(r, 0, 0, PASS), 8'h00);
    check(tag, alu_result, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9: reset state of every register
    for (int r = 1; r <= 7; r++) read_reg(r, 8'h00, "R9 reset value");
    check("R6 zero after reset", {7'b0, zero_flag}, 8'h01);

    // R1/R4/R5/R6 table: preload R1, R2, run op into R3, read R3 back
    for (int i = 0; i < NVEC; i++) begin
      drive(cw(0, 0, 1, PASS), VEC[i][24:17]);
      drive(cw(0, 0, 2, PASS), VEC[i][16:9]);
      drive(cw(1, 2, 3, VEC[i][29:25]), 8'h00);
      check($sformatf("R1/R4 result vec %0d", i), alu_result, VEC[i][8:1]);
      check($sformatf("R5 carry vec %0d", i), {7'b0, carry_out}, {7'b0, VEC[i][0]});
      check($sformatf("R6 zero vec %0d", i), {7'b0, zero_flag},
            {7'b0, VEC[i][8:1] == 8'h00});
      read_reg(3, VEC[i][8:1], $sformatf("R3 destination vec %0d", i));
    end

    // R2: load distinct values, then select each on B and on A
    for (int r = 1; r <= 7; r++) drive(cw(0, 0, r, PASS), 8'(r * 17));
    for (int r = 1; r <= 7; r++) begin
      drive(cw(0, r, 0, ADD), 8'h00);
      check($sformatf("R2 B select R%0d", r), alu_result, 8'(r * 17));
      drive(cw(r, 0, 0, PASS), 8'h99);
      check($sformatf("R2 A select R%0d", r), alu_result, 8'(r * 17));
    end
    drive(cw(0, 0, 0, ADD), 8'h21);
    check("R2 external on both operands", alu_result, 8'h42);

    // R3: destination 0 writes nothing; destination 5 writes only R5
    drive(cw(0, 0, 0, PASS), 8'hEE);
    for (int r = 1; r <= 7; r++) read_reg(r, 8'(r * 17), "R3 no write on destination 0");
    drive(cw(0, 0, 5, PASS), 8'h3C);
    for (int r = 1; r <= 7; r++)
      read_reg(r, (r == 5) ? 8'h3C : 8'(r * 17), "R3 single destination");

    // R8: same register as source and destination
    drive(cw(4, 4, 4, ADD), 8'h00);
    check("R8 old value used in cycle", alu_result, 8'h88);
    read_reg(4, 8'h88, "R8 new value next cycle");
    drive(cw(4, 0, 4, INC), 8'h00);
    check("R8 increment in place", alu_result, 8'h89);
    read_reg(4, 8'h89, "R8 incremented value");

    // R7: result follows the external bus without a clock edge
    drive(cw(0, 7, 0, OR_), 8'h00);
    check("R7 combinational result", alu_result, 8'h77);
    ext_data = 8'h88;
    #1;
    check("R7 result tracks bus", alu_result, 8'hFF);

    // R9: reset after writes
    @(negedge clk);
    rst = 1'b1;
    ctrl_word = cw(0, 0, 0, PASS);
    @(negedge clk);
    rst = 1'b0;
    for (int r = 1; r <= 7; r++) read_reg(r, 8'h00, "R9 cleared after use");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule